// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block steers the operating point of a processor core whose supply comes from a fast regulator on the die. A requested level picks one of four voltage/frequency pairs. The block then drives two codes. The first is a regulator voltage target in 4 mV units. The second is a clock-select code for the clock generator. The voltage target never jumps. It moves one unit at a time, with `TICKS_PER_STEP` clock cycles between steps, which sets a fixed slew rate.

The order of the two changes depends on the direction:

- **Raising the level.** The voltage climbs first. The clock select moves up in a single step only after the voltage target has arrived.
- **Lowering the level.** The clock select drops at once. The voltage then walks down behind it.

The core keeps running through every transient. The block only raises a busy flag while a transition is in flight. It also keeps a running count of the cycles spent at a reduced clock while the voltage is still above that clock's nominal level, so that this overhead can be accounted.

A request that arrives while a transition is in flight is parked in a single slot. A newer request replaces an older one in that slot. The parked request is acted on once the current transition has finished.

Top module: `vf_step_sequencer`

## Requirements
- R1: After reset the block sits at level 3 with clock select 3, voltage code 250, settled high, busy low and an overhead count of 0.
- R2: Level L (0..3) maps to voltage code 160+30·L in 4 mV units, so 3 gives 1.00 V, 2 gives 0.88 V, 1 gives 0.76 V and 0 gives 0.64 V. The clock select carries the level number, where 3 is 2.4 GHz, 2 is 1.8 GHz, 1 is 1.2 GHz and 0 is 0.6 GHz.
- R3: On an upward request the clock select holds its old value while the voltage climbs. It takes the new level on the clock edge after the voltage code equals the new level's code.
- R4: On a downward request the clock select takes the new level on the same edge that samples the request. The voltage code has not moved at that edge and then falls toward the new code.
- R5: The voltage code changes by at most one unit per cycle. It steps once every `TICKS_PER_STEP` cycles, counted from the edge that accepts the request, so a swing of d units arrives d·`TICKS_PER_STEP` cycles after that edge.
- R6: Busy goes high on the edge that accepts a request that changes the level. It falls one cycle after the voltage arrives. Settled is always the inverse of busy.
- R7: A downward transition of d units adds exactly d·`TICKS_PER_STEP` to the overhead count. An upward transition leaves the count unchanged.
- R8: A request sampled while busy is held and served on the second edge after the transition ends. A later request sampled while busy replaces the held one.
- R9: A request for the level already in force while settled is ignored: busy stays low and neither code changes.
- R10: While settled, the voltage code equals the code of the level on the clock select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled each edge |
| reqLevel | input | 2 | Requested operating level, 0 (lowest) to 3 (highest) |
| vTarget | output | 8 | Regulator voltage target in 4 mV units |
| clkSel | output | 2 | Clock select code, equal to the level now in force |
| busy | output | 1 | Transition in progress; the core keeps running |
| settled | output | 1 | No transition in progress |
| ovhCount | output | 32 | Cumulative count of overhead cycles |

## Verification
The hardest situation to reach is a request that lands mid-transient and is then overtaken by a second request before the first transient finishes. The bench starts a downward move and issues two further requests while the voltage is still ramping. It then checks three things:

- the level and voltage in the single idle cycle between the two transients;
- that the newer request is the one that runs;
- that the discarded request never appears afterwards.

The exact arrival edges of both ramps are derived from the step period. The cumulative overhead count is compared against the sum over both downward moves.

// File: rtl/vfseq_pkg.sv
package vfseq_pkg;
  localparam int LVL_W   = 2;
  localparam int VCODE_W = 8;
  localparam int VBASE   = 160;  // lowest level, 4 mV units
  localparam int VSTEP   = 30;   // distance between adjacent levels

  typedef logic [LVL_W-1:0]   level_t;
  typedef logic [VCODE_W-1:0] vcode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_UP, ST_DOWN} seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   loadGoal;
    level_t goalLvl;
    logic   stepV;
    logic   setClk;
    level_t clkLvl;
    logic   cntOvh;
  } dpCmd_t;

  function automatic vcode_t lvlCode(input level_t l);
    return vcode_t'(VBASE + VSTEP * int'(l));
  endfunction
endpackage

// File: rtl/vfseq_ctrl.sv
module vfseq_ctrl
  import vfseq_pkg::*;
#(
  parameter int TICKS_PER_STEP = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  level_t reqLevel,
  input  level_t clkLvlNow,
  input  logic   atGoal,
  output dpCmd_t cmd,
  output logic   busy
);
  localparam int TICK_W = $clog2(TICKS_PER_STEP + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_STEP - 1);

  seqState_t stateQ, stateD;
  logic [TICK_W-1:0] tickQ, tickD;
  logic   pendValidQ, pendValidD;
  level_t pendLvlQ, pendLvlD;
  level_t goalLvlQ, goalLvlD;
  logic   haveReq;
  level_t effLvl;

  always_comb begin
    haveReq    = reqValid | pendValidQ;
    effLvl     = reqValid ? reqLevel : pendLvlQ;
    cmd        = '0;
    stateD     = stateQ;
    tickD      = tickQ;
    pendValidD = pendValidQ;
    pendLvlD   = pendLvlQ;
    goalLvlD   = goalLvlQ;
    case (stateQ)
      ST_IDLE: begin
        tickD = '0;
        if (haveReq) begin
          pendValidD = 1'b0;
          if (effLvl > clkLvlNow) begin
            cmd.loadGoal = 1'b1;
            cmd.goalLvl  = effLvl;
            goalLvlD     = effLvl;
            stateD       = ST_UP;
          end else if (effLvl < clkLvlNow) begin
            cmd.loadGoal = 1'b1;
            cmd.goalLvl  = effLvl;
            cmd.setClk   = 1'b1;
            cmd.clkLvl   = effLvl;
            goalLvlD     = effLvl;
            stateD       = ST_DOWN;
          end
        end
      end
      ST_UP, ST_DOWN: begin
        if (reqValid) begin
          pendValidD = 1'b1;
          pendLvlD   = reqLevel;
        end
        if (atGoal) begin
          stateD = ST_IDLE;
          tickD  = '0;
          if (stateQ == ST_UP) begin
            cmd.setClk = 1'b1;
            cmd.clkLvl = goalLvlQ;
          end
        end else begin
          cmd.cntOvh = (stateQ == ST_DOWN);
          if (tickQ == TICK_LAST) begin
            cmd.stepV = 1'b1;
            tickD     = '0;
          end else begin
            tickD = tickQ + 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      tickQ      <= '0;
      pendValidQ <= 1'b0;
      pendLvlQ   <= '0;
      goalLvlQ   <= level_t'(2**LVL_W - 1);
    end else begin
      stateQ     <= stateD;
      tickQ      <= tickD;
      pendValidQ <= pendValidD;
      pendLvlQ   <= pendLvlD;
      goalLvlQ   <= goalLvlD;
    end
  end

  assign busy = (stateQ != ST_IDLE);

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickQ <= TICK_LAST);  // R5
  AST_PEND_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendValidQ) |-> $past(stateQ) != ST_IDLE);  // R8
  AST_UP_HOLDS_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_UP && $past(stateQ) == ST_UP) |-> $stable(clkLvlNow));  // R3
endmodule

// File: rtl/vfseq_dp.sv
module vfseq_dp
  import vfseq_pkg::*;
#(
  parameter int OVH_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  output vcode_t           vTarget,
  output level_t           clkSel,
  output logic [OVH_W-1:0] ovhCount,
  output logic             atGoal
);
  localparam level_t LVL_TOP = level_t'(2**LVL_W - 1);

  vcode_t vTargetQ, goalCodeQ;
  level_t clkSelQ;
  logic [OVH_W-1:0] ovhQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vTargetQ  <= lvlCode(LVL_TOP);
      goalCodeQ <= lvlCode(LVL_TOP);
      clkSelQ   <= LVL_TOP;
      ovhQ      <= '0;
    end else begin
      if (cmd.loadGoal) goalCodeQ <= lvlCode(cmd.goalLvl);
      if (cmd.setClk)   clkSelQ   <= cmd.clkLvl;
      if (cmd.cntOvh)   ovhQ      <= ovhQ + 1'b1;
      if (cmd.stepV) begin
        if (vTargetQ < goalCodeQ) vTargetQ <= vTargetQ + 1'b1;
        else                      vTargetQ <= vTargetQ - 1'b1;
      end
    end
  end

  assign atGoal   = (vTargetQ == goalCodeQ);
  assign vTarget  = vTargetQ;
  assign clkSel   = clkSelQ;
  assign ovhCount = ovhQ;

  AST_CLK_UP_AFTER_V: assert property (@(posedge clk) disable iff (!rstN)
    (clkSelQ > $past(clkSelQ)) |-> vTargetQ == lvlCode(clkSelQ));  // R3
  AST_CLK_DOWN_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (clkSelQ < $past(clkSelQ)) |-> vTargetQ == lvlCode($past(clkSelQ)));  // R4
  AST_V_SLEW: assert property (@(posedge clk) disable iff (!rstN)
    (vTargetQ == $past(vTargetQ)) || (vTargetQ == $past(vTargetQ) + 1'b1) ||
    (vTargetQ == $past(vTargetQ) - 1'b1));  // R5
  AST_V_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    vTargetQ >= lvlCode('0) && vTargetQ <= lvlCode(LVL_TOP));  // R2
  AST_OVH_ONLY_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    (ovhQ != $past(ovhQ)) |-> $past(vTargetQ) > lvlCode($past(clkSelQ)));  // R7
endmodule

// File: rtl/vf_step_sequencer.sv
module vf_step_sequencer
  import vfseq_pkg::*;
#(
  parameter int TICKS_PER_STEP = 4,
  parameter int OVH_W          = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [LVL_W-1:0]   reqLevel,
  output logic [VCODE_W-1:0] vTarget,
  output logic [LVL_W-1:0]   clkSel,
  output logic               busy,
  output logic               settled,
  output logic [OVH_W-1:0]   ovhCount
);
  dpCmd_t cmd;
  logic   atGoal;

  vfseq_ctrl #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLevel(reqLevel),
    .clkLvlNow(clkSel), .atGoal(atGoal), .cmd(cmd), .busy(busy)
  );

  vfseq_dp #(.OVH_W(OVH_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .vTarget(vTarget),
    .clkSel(clkSel), .ovhCount(ovhCount), .atGoal(atGoal)
  );

  assign settled = ~busy;

  AST_SETTLED_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    settled |-> vTarget == lvlCode(clkSel));  // R10
endmodule

// File: tb/vf_step_sequencer_bench.sv
module vf_step_sequencer_bench;
  localparam int TPS = 4;
  localparam int WD  = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqLevel = '0;
  logic [7:0] vTarget;
  logic [1:0] clkSel;
  logic busy, settled;
  logic [31:0] ovhCount;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vf_step_sequencer #(.TICKS_PER_STEP(TPS), .OVH_W(32)) u_vf_step_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLevel(reqLevel),
    .vTarget(vTarget), .clkSel(clkSel), .busy(busy), .settled(settled),
    .ovhCount(ovhCount)
  );

  function automatic int code(input int l);
    return 160 + 30 * l;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives a one-cycle request; returns just after the sampling edge.
  task automatic sendReq(input int l);
    reqValid = 1'b1;
    reqLevel = 2'(l);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tReset();
    chk("R1", "clkSel", int'(clkSel), 3);
    chk("R1", "vTarget", int'(vTarget), code(3));
    chk("R1", "settled", int'(settled), 1);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "ovhCount", int'(ovhCount), 0);
  endtask

  task automatic tDownFull();
    int ovh0 = int'(ovhCount);
    int d = code(3) - code(0);
    sendReq(0);
    chk("R4", "clkSel on accept", int'(clkSel), 0);
    chk("R4", "vTarget unmoved on accept", int'(vTarget), code(3));
    chk("R6", "busy on accept", int'(busy), 1);
    chk("R6", "settled on accept", int'(settled), 0);
    cyc(TPS - 1);
    chk("R5", "before first step", int'(vTarget), code(3));
    cyc(1);
    chk("R5", "first step", int'(vTarget), code(3) - 1);
    cyc(d * TPS - TPS);
    chk("R5", "arrival", int'(vTarget), code(0));
    chk("R6", "busy at arrival", int'(busy), 1);
    cyc(1);
    chk("R6", "settled after arrival", int'(settled), 1);
    chk("R2", "level 0 code", int'(vTarget), code(0));
    chk("R7", "overhead down", int'(ovhCount) - ovh0, d * TPS);
  endtask

  task automatic tUp();
    int ovh0 = int'(ovhCount);
    int d = code(2) - code(0);
    sendReq(2);
    chk("R3", "clkSel held on accept", int'(clkSel), 0);
    chk("R6", "busy up", int'(busy), 1);
    cyc(d * TPS - 1);
    chk("R5", "one unit short", int'(vTarget), code(2) - 1);
    cyc(1);
    chk("R3", "voltage arrived", int'(vTarget), code(2));
    chk("R3", "clkSel still low", int'(clkSel), 0);
    cyc(1);
    chk("R3", "clkSel raised", int'(clkSel), 2);
    chk("R6", "settled up", int'(settled), 1);
    chk("R7", "no overhead up", int'(ovhCount) - ovh0, 0);
  endtask

  task automatic tSame();
    sendReq(2);
    chk("R9", "busy same", int'(busy), 0);
    chk("R9", "clkSel same", int'(clkSel), 2);
    cyc(TPS + 2);
    chk("R9", "vTarget same", int'(vTarget), code(2));
    chk("R10", "aligned", int'(vTarget), code(int'(clkSel)));
  endtask

  task automatic tPending();
    int ovh0 = int'(ovhCount);
    int d1 = code(2) - code(1);
    int d2 = code(1) - code(0);
    sendReq(1);             // edge k
    cyc(10);
    sendReq(3);             // k+11, parked
    sendReq(0);             // k+12, replaces
    cyc(d1 * TPS - 12);     // k + d1*TPS
    chk("R8", "first ramp arrived", int'(vTarget), code(1));
    chk("R8", "still busy", int'(busy), 1);
    cyc(1);
    chk("R8", "idle gap", int'(busy), 0);
    chk("R8", "idle gap level", int'(clkSel), 1);
    cyc(1);
    chk("R8", "newest served", int'(clkSel), 0);
    chk("R8", "busy again", int'(busy), 1);
    cyc(d2 * TPS + 1);
    chk("R8", "second ramp done", int'(vTarget), code(0));
    chk("R6", "settled end", int'(settled), 1);
    chk("R7", "overhead two downs", int'(ovhCount) - ovh0, (d1 + d2) * TPS);
    cyc(TPS * 3);
    chk("R8", "discarded request absent", int'(clkSel), 0);
    chk("R8", "no further busy", int'(busy), 0);
  endtask

  task automatic tUpFull();
    int d = code(3) - code(0);
    sendReq(3);
    cyc(d * TPS);
    chk("R5", "full swing time", int'(vTarget), code(3));
    chk("R3", "clk held full", int'(clkSel), 0);
    cyc(1);
    chk("R3", "clk top", int'(clkSel), 3);
    chk("R10", "aligned top", int'(vTarget), code(int'(clkSel)));
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    tReset();
    tDownFull();
    tUp();
    tSame();
    tPending();
    tUpFull();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule